// File: doc/BRIEF.md
# Pong Court Pixel Painter

This block colours one pixel of the Pong playfield at a time. It is purely combinational. A scan generator supplies the current row, the current column and a blanking flag. The game controller supplies the ball position and the paddle position. The block returns 8-bit red, green and blue values for that pixel in the same cycle.

The picture has four layers. A two-letter logo in dark blue forms the background. A white paddle sits in a fixed column band near the left edge. A yellow 8x8 ball moves over the court. The ball is deliberately left undrawn on every pixel that belongs to a logo letter, so it seems to pass behind the letters. The paddle is drawn over everything else. During blanking the block drives black.

Top module: `court_painter`

## Requirements
- R1: While `blanking` is 1, `red`, `green` and `blue` are all 0x00, whatever the other inputs are.
- R2: With `blanking` at 0, a pixel in columns 16..23 (inclusive) and rows `paddle_top`..`paddle_top`+63 (inclusive) is white (0xFF, 0xFF, 0xFF). Column 15, column 24 and row `paddle_top`+64 are not paddle.
- R3: With the default logo origin (column 200, row 160), the logo is the union of seven filled rectangles. The first letter has two uprights (columns 200..223 and 280..303, rows 160..319) and two crossbars (columns 200..303, rows 160..183 and rows 232..255). The second letter has an upright (columns 340..363, rows 160..319), a top bar (columns 340..443, rows 160..183) and a shorter middle bar (columns 340..411, rows 232..255). Logo pixels are coloured red 0x00, green 0x30, blue 0x87.
- R4: A pixel in columns `ball_col`..`ball_col`+7 and rows `ball_row`..`ball_row`+7 (inclusive) that is neither paddle nor logo is yellow (0xFF, 0xFF, 0x00).
- R5: A pixel that is both ball and logo shows the logo colour, never yellow.
- R6: A pixel that is both paddle and ball shows white.
- R7: A pixel that is not blanked and is not paddle, logo or ball is black. This includes the enclosed hole inside the first letter.
- R8: Ball and paddle extents are computed 12 bits wide and do not wrap past column or row 2047. A ball at column 2044 does not cover column 2, and a paddle at row 2020 does not cover row 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| scan_row | input | 11 | Row of the pixel being painted |
| scan_col | input | 11 | Column of the pixel being painted |
| blanking | input | 1 | High outside the visible area |
| ball_col | input | 11 | Left column of the ball |
| ball_row | input | 11 | Top row of the ball |
| paddle_top | input | 11 | Top row of the paddle |
| red | output | 8 | Red level |
| green | output | 8 | Green level |
| blue | output | 8 | Blue level |

## Verification
Three layers can claim the same pixel: ball with logo, ball with paddle, and any layer with blanking. Each overlap is set up by placing the ball so that its 8x8 box straddles a letter edge or the paddle band. Pixels are then sampled on both sides of the edge. A pixel inside the overlap must show the higher layer's colour. A pixel just outside it must show yellow, which proves the ball was present there and lost only on priority.

// File: rtl/court_pkg.sv
package court_pkg;

    localparam int COORD_W = 11;
    localparam int WIDE_W  = COORD_W + 1;
    localparam int COLOR_W = 8;

    typedef logic [COORD_W-1:0] coord_t;
    typedef logic [WIDE_W-1:0]  wide_t;

    typedef struct packed {
        logic [COLOR_W-1:0] r;
        logic [COLOR_W-1:0] g;
        logic [COLOR_W-1:0] b;
    } rgb_t;

    typedef enum logic [2:0] {
        LAYER_DARK,
        LAYER_PADDLE,
        LAYER_LOGO,
        LAYER_BALL,
        LAYER_FLOOR
    } layer_t;

    localparam rgb_t COL_BLACK  = '{r: 8'h00, g: 8'h00, b: 8'h00};
    localparam rgb_t COL_WHITE  = '{r: 8'hFF, g: 8'hFF, b: 8'hFF};
    localparam rgb_t COL_YELLOW = '{r: 8'hFF, g: 8'hFF, b: 8'h00};
    localparam rgb_t COL_NAVY   = '{r: 8'h00, g: 8'h30, b: 8'h87};

    // Letter geometry, relative to the logo origin.
    localparam int STROKE    = 24;
    localparam int LETTER_H  = 160;
    localparam int LETTER_W  = 104;
    localparam int SECOND_X  = 140;
    localparam int MIDBAR_Y  = 72;
    localparam int SHORT_BAR = 72;
    localparam int NUM_RECTS = 7;

    typedef struct packed {
        int x;
        int w;
        int y;
        int h;
    } rect_t;

    function automatic rect_t logo_rect(input int idx);
        rect_t q;
        case (idx)
            0: q = '{x: 0,                     w: STROKE,    y: 0,        h: LETTER_H};
            1: q = '{x: LETTER_W - STROKE,     w: STROKE,    y: 0,        h: LETTER_H};
            2: q = '{x: 0,                     w: LETTER_W,  y: 0,        h: STROKE};
            3: q = '{x: 0,                     w: LETTER_W,  y: MIDBAR_Y, h: STROKE};
            4: q = '{x: SECOND_X,              w: STROKE,    y: 0,        h: LETTER_H};
            5: q = '{x: SECOND_X,              w: LETTER_W,  y: 0,        h: STROKE};
            default: q = '{x: SECOND_X,        w: SHORT_BAR, y: MIDBAR_Y, h: STROKE};
        endcase
        return q;
    endfunction

    // Half-open span test done one bit wider, so the end never wraps.
    function automatic logic in_span(input coord_t pos, input coord_t start, input wide_t len);
        wide_t p;
        wide_t s;
        p = {1'b0, pos};
        s = {1'b0, start};
        return (p >= s) && (p < s + len);
    endfunction

endpackage

// File: rtl/box_hit.sv
module box_hit
    import court_pkg::*;
#(
    parameter int W = 8,
    parameter int H = 8
) (
    input  coord_t col,
    input  coord_t row,
    input  coord_t x0,
    input  coord_t y0,
    output logic   hit
);
    localparam wide_t W_EXT = WIDE_W'(W);
    localparam wide_t H_EXT = WIDE_W'(H);

    assign hit = in_span(col, x0, W_EXT) && in_span(row, y0, H_EXT);

    // A hit implies the pixel lies at offset below the box size from its corner.
    always_comb begin
        if (!$isunknown({col, row, x0, y0}) && hit) begin
            assert_box_offset_R8: assert ((({1'b0, col} - {1'b0, x0}) < W_EXT) &&
                                          (({1'b0, row} - {1'b0, y0}) < H_EXT))
                else $error("box hit outside its extent");
        end
    end
endmodule

// File: rtl/logo_mask.sv
module logo_mask
    import court_pkg::*;
#(
    parameter int ORG_X = 200,
    parameter int ORG_Y = 160
) (
    input  coord_t col,
    input  coord_t row,
    output logic   on_logo
);
    logic [NUM_RECTS-1:0] part_hit;

    for (genvar i = 0; i < NUM_RECTS; i++) begin : g_rect
        localparam rect_t R = logo_rect(i);
        box_hit #(
            .W(R.w),
            .H(R.h)
        ) i_part (
            .col(col),
            .row(row),
            .x0 (COORD_W'(ORG_X + R.x)),
            .y0 (COORD_W'(ORG_Y + R.y)),
            .hit(part_hit[i])
        );
    end

    assign on_logo = |part_hit;
endmodule

// File: rtl/court_painter.sv
module court_painter
    import court_pkg::*;
#(
    parameter int LOGO_X     = 200,
    parameter int LOGO_Y     = 160,
    parameter int PADDLE_COL = 16,
    parameter int PADDLE_W   = 8,
    parameter int PADDLE_H   = 64,
    parameter int BALL_SIZE  = 8
) (
    input  logic [10:0] scan_row,
    input  logic [10:0] scan_col,
    input  logic        blanking,
    input  logic [10:0] ball_col,
    input  logic [10:0] ball_row,
    input  logic [10:0] paddle_top,
    output logic [7:0]  red,
    output logic [7:0]  green,
    output logic [7:0]  blue
);
    localparam coord_t PAD_X = COORD_W'(PADDLE_COL);

    logic   paddle_hit;
    logic   logo_hit;
    logic   ball_hit;
    layer_t layer;
    rgb_t   pix;

    box_hit #(.W(PADDLE_W), .H(PADDLE_H)) i_paddle (
        .col(scan_col), .row(scan_row), .x0(PAD_X), .y0(paddle_top), .hit(paddle_hit)
    );

    box_hit #(.W(BALL_SIZE), .H(BALL_SIZE)) i_ball (
        .col(scan_col), .row(scan_row), .x0(ball_col), .y0(ball_row), .hit(ball_hit)
    );

    logo_mask #(.ORG_X(LOGO_X), .ORG_Y(LOGO_Y)) i_logo (
        .col(scan_col), .row(scan_row), .on_logo(logo_hit)
    );

    // Layer priority: blank, paddle, logo, ball, floor.
    always_comb begin
        if (blanking)        layer = LAYER_DARK;
        else if (paddle_hit) layer = LAYER_PADDLE;
        else if (logo_hit)   layer = LAYER_LOGO;
        else if (ball_hit)   layer = LAYER_BALL;
        else                 layer = LAYER_FLOOR;
    end

    always_comb begin
        case (layer)
            LAYER_PADDLE: pix = COL_WHITE;
            LAYER_LOGO:   pix = COL_NAVY;
            LAYER_BALL:   pix = COL_YELLOW;
            default:      pix = COL_BLACK;
        endcase
    end

    assign red   = pix.r;
    assign green = pix.g;
    assign blue  = pix.b;

    always_comb begin
        if (!$isunknown({blanking, paddle_hit, logo_hit, ball_hit})) begin
            if (blanking) begin
                assert_blank_dark_R1: assert ({red, green, blue} == 24'h0)
                    else $error("colour during blanking");
            end
            if (!blanking && logo_hit) begin
                assert_ball_hidden_R5: assert (pix != COL_YELLOW)
                    else $error("ball drawn over logo");
            end
            if (!blanking && paddle_hit) begin
                assert_paddle_on_top_R6: assert (pix == COL_WHITE)
                    else $error("paddle pixel not white");
            end
            if (!blanking && ball_hit && !logo_hit && !paddle_hit) begin
                assert_ball_shown_R4: assert (pix == COL_YELLOW)
                    else $error("visible ball pixel not yellow");
            end
        end
    end
endmodule

// File: tb/test_court_painter.sv
module test_court_painter;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        blank;
        logic [10:0] row;
        logic [10:0] col;
        logic [10:0] bx;
        logic [10:0] by;
        logic [10:0] py;
        logic [23:0] rgb;
        logic [3:0]  req;
    } vec_t;

    localparam logic [23:0] BLK = 24'h000000;
    localparam logic [23:0] WHT = 24'hFFFFFF;
    localparam logic [23:0] YEL = 24'hFFFF00;
    localparam logic [23:0] NAV = 24'h003087;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 11'd100,  11'd20,   11'd500,  11'd300, 11'd80,   BLK, 4'd1}, // R1 paddle pixel blanked
        '{1'b1, 11'd160,  11'd200,  11'd500,  11'd300, 11'd80,   BLK, 4'd1}, // R1 logo pixel blanked
        '{1'b1, 11'd300,  11'd500,  11'd500,  11'd300, 11'd80,   BLK, 4'd1}, // R1 ball pixel blanked
        '{1'b0, 11'd80,   11'd16,   11'd500,  11'd300, 11'd80,   WHT, 4'd2}, // R2 top-left corner
        '{1'b0, 11'd143,  11'd23,   11'd500,  11'd300, 11'd80,   WHT, 4'd2}, // R2 bottom-right corner
        '{1'b0, 11'd144,  11'd23,   11'd500,  11'd300, 11'd80,   BLK, 4'd2}, // R2 row below
        '{1'b0, 11'd100,  11'd24,   11'd500,  11'd300, 11'd80,   BLK, 4'd2}, // R2 column right
        '{1'b0, 11'd100,  11'd15,   11'd500,  11'd300, 11'd80,   BLK, 4'd2}, // R2 column left
        '{1'b0, 11'd160,  11'd200,  11'd500,  11'd300, 11'd80,   NAV, 4'd3}, // R3 first letter corner
        '{1'b0, 11'd319,  11'd303,  11'd500,  11'd300, 11'd80,   NAV, 4'd3}, // R3 right upright foot
        '{1'b0, 11'd255,  11'd411,  11'd500,  11'd300, 11'd80,   NAV, 4'd3}, // R3 short bar end
        '{1'b0, 11'd240,  11'd412,  11'd500,  11'd300, 11'd80,   BLK, 4'd3}, // R3 past short bar
        '{1'b0, 11'd183,  11'd443,  11'd500,  11'd300, 11'd80,   NAV, 4'd3}, // R3 top bar end
        '{1'b0, 11'd320,  11'd350,  11'd500,  11'd300, 11'd80,   BLK, 4'd3}, // R3 below upright
        '{1'b0, 11'd200,  11'd250,  11'd500,  11'd300, 11'd80,   BLK, 4'd7}, // R7 hole in first letter
        '{1'b0, 11'd300,  11'd500,  11'd500,  11'd300, 11'd80,   YEL, 4'd4}, // R4 ball corner
        '{1'b0, 11'd307,  11'd507,  11'd500,  11'd300, 11'd80,   YEL, 4'd4}, // R4 ball far corner
        '{1'b0, 11'd303,  11'd508,  11'd500,  11'd300, 11'd80,   BLK, 4'd4}, // R4 right of ball
        '{1'b0, 11'd308,  11'd503,  11'd500,  11'd300, 11'd80,   BLK, 4'd4}, // R4 below ball
        '{1'b0, 11'd163,  11'd201,  11'd196,  11'd160, 11'd80,   NAV, 4'd5}, // R5 ball behind letter
        '{1'b0, 11'd163,  11'd199,  11'd196,  11'd160, 11'd80,   YEL, 4'd5}, // R5 same ball off letter
        '{1'b0, 11'd92,   11'd20,   11'd18,   11'd90,  11'd80,   WHT, 4'd6}, // R6 paddle over ball
        '{1'b0, 11'd92,   11'd24,   11'd18,   11'd90,  11'd80,   YEL, 4'd6}, // R6 ball beside paddle
        '{1'b0, 11'd101,  11'd2,    11'd2044, 11'd100, 11'd80,   BLK, 4'd8}, // R8 no column wrap
        '{1'b0, 11'd101,  11'd2047, 11'd2044, 11'd100, 11'd80,   YEL, 4'd8}, // R8 last column still ball
        '{1'b0, 11'd3,    11'd20,   11'd500,  11'd300, 11'd2020, BLK, 4'd8}  // R8 no paddle row wrap
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] scan_row = '0;
    logic [10:0] scan_col = '0;
    logic        blanking = 1'b1;
    logic [10:0] ball_col = '0;
    logic [10:0] ball_row = '0;
    logic [10:0] paddle_top = '0;
    logic [7:0]  red;
    logic [7:0]  green;
    logic [7:0]  blue;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    court_painter i_court_painter (
        .scan_row(scan_row), .scan_col(scan_col), .blanking(blanking),
        .ball_col(ball_col), .ball_row(ball_row), .paddle_top(paddle_top),
        .red(red), .green(green), .blue(blue)
    );

    task automatic apply(input vec_t v);
        @(posedge clk);
        blanking   = v.blank;
        scan_row   = v.row;
        scan_col   = v.col;
        ball_col   = v.bx;
        ball_row   = v.by;
        paddle_top = v.py;
        @(negedge clk);
        checks++;
        if ({red, green, blue} !== v.rgb) begin
            fails++;
            $display("FAIL R%0d row=%0d col=%0d actual=%06h expected=%06h",
                     v.req, v.row, v.col, {red, green, blue}, v.rgb);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset-time state: blanking held high gives black (R1)
        @(negedge clk);
        checks++;
        if ({red, green, blue} !== 24'h0) begin
            fails++;
            $display("FAIL R1 reset actual=%06h expected=000000", {red, green, blue});
        end
        for (int i = 0; i < NV; i++) apply(VECS[i]);
        // R5 sweep: ball parked on the first letter's corner; every covered
        // pixel on a letter is navy, every covered pixel off it is yellow
        for (int dy = 0; dy < 8; dy++) begin
            for (int dx = 0; dx < 8; dx++) begin
                vec_t v;
                int c;
                int r;
                c = 196 + dx;
                r = 156 + dy;
                v.blank = 1'b0;
                v.row = 11'(r);
                v.col = 11'(c);
                v.bx = 11'd196;
                v.by = 11'd156;
                v.py = 11'd80;
                v.rgb = (c >= 200 && r >= 160) ? NAV : YEL;
                v.req = 4'd5;
                apply(v);
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(CLK_PERIOD * 20000);
                checks++;
                fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule